// File: doc/BRIEF.md
# SPI Buffer and Status Flag Controller

This block holds the data buffering and status flags of a byte-wide SPI peripheral. It sits between a CPU register bus and an 8-bit shift engine. It keeps one transmit holding register and one receive holding register. From these it produces a transmit-empty flag, a receive-full flag, an overflow flag, a mode-fault flag and a transmit interrupt request. It also selects the master bit-clock divisor.

The CPU side is a set of single-cycle strobes: control write, status read, transmit data write and receive data read. Every flag is a level output, so a status read has no data path of its own. The shift engine is modelled by two handshake pulses. `load_take` means the engine has taken the transmit byte, and `byte_rcvd` means a full byte has arrived on `rx_byte`. The engine reports an active transfer on `xfer_busy`, and the slave-select pin level arrives on `ss_in`.

The overflow and mode-fault flags can only be cleared by an ordered pair of accesses. For overflow the pair is a status read followed by a receive read. For mode fault it is a status read followed by a control write. A fresh setting of the flag between the two steps cancels the first step.

Top module: `spi_flag_ctl`

## Requirements
- R1: `tx_empty` is 1 after reset. A `tx_wr` strobe latches `tx_wdata` into `tx_byte` and clears `tx_empty`. A `load_take` pulse sets `tx_empty`. When both come in the same cycle, the write wins. The result is visible one cycle later.
- R2: `tx_irq` is 1 exactly when `tx_empty` is 1 and the interrupt-enable bit is 1. The interrupt-enable bit is control bit 3.
- R3: If a `byte_rcvd` pulse arrives while `rx_full` is 0, or while `rx_rd` is pulsed in the same cycle, `rx_byte` is loaded into `rx_rdata` and `rx_full` is set. A `rx_rd` strobe clears `rx_full`.
- R4: If a `byte_rcvd` pulse arrives while `rx_full` is 1 and no `rx_rd` is present, `ovf` is set. In that case `rx_rdata` keeps the old byte and the new byte is discarded.
- R5: `ovf` clears only after a `stat_rd` seen while `ovf` is 1, followed later by a `rx_rd`. A `rx_rd` alone leaves `ovf` at 1. A new overflow between the two steps cancels the first step. Reset clears `ovf`.
- R6: In master role with SPI enable and fault enable both 1, `modf` is set whenever `ss_in` is 0. Master is control bit 4, SPI enable is control bit 5, and fault enable is control bit 2.
- R7: In slave role with SPI enable and fault enable both 1, `modf` is set only while `ss_in` is 1 and `xfer_busy` is 1.
- R8: `modf` clears only after a `stat_rd` seen while `modf` is 1, followed later by a `ctrl_wr`. A control write that clears fault enable, with no prior status read, leaves `modf` at 1. Reset clears `modf`.
- R9: With fault enable at 0, the level of `ss_in` never sets `modf`, in either role.
- R10: In master role, rate code `ctrl[1:0]` gives `clk_div` values as follows: 00 gives 2, 01 gives 8, 10 gives 32 and 11 gives 128. In slave role `clk_div` is 0 for any code. Reset clears the code to 00.
- R11: `ss_gpio` is 1 only when SPI enable is 1, master is 1 and fault enable is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_wdata | input | 8 | Control data: [1:0] rate, [2] fault enable, [3] irq enable, [4] master, [5] SPI enable |
| stat_rd | input | 1 | Status register read strobe |
| tx_wr | input | 1 | Transmit data write strobe |
| tx_wdata | input | DW | Transmit data |
| rx_rd | input | 1 | Receive data read strobe |
| load_take | input | 1 | Shift engine took the transmit byte |
| byte_rcvd | input | 1 | Shift engine completed a received byte |
| rx_byte | input | DW | Received byte from the shift engine |
| xfer_busy | input | 1 | Transfer in progress |
| ss_in | input | 1 | Slave-select pin level |
| tx_byte | output | DW | Transmit holding register |
| rx_rdata | output | DW | Receive holding register |
| tx_empty | output | 1 | Transmit register empty flag |
| rx_full | output | 1 | Receive register full flag |
| ovf | output | 1 | Overflow flag |
| modf | output | 1 | Mode-fault flag |
| tx_irq | output | 1 | Transmit interrupt request |
| ss_gpio | output | 1 | Slave-select pin free for general use |
| clk_div | output | 8 | Master bit-clock divisor |

## Verification
Every flag and holding register changes on the first clock edge after the strobe or pulse that affects it. `tx_irq`, `ss_gpio` and `clk_div` are combinational from registered state, so they follow that same edge. Each bench task drives its strobe for exactly one cycle, starting at a falling edge, and samples at the next falling edge. The sample therefore falls half a period after the edge that holds the result. For a two-step clear, the bench checks the flag after each step, so the early step is confirmed to have no visible effect.

// File: rtl/spi_flag_ctl.sv
module spi_flag_ctl #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctrl_wr,
  input  logic [7:0]    ctrl_wdata,
  input  logic          stat_rd,
  input  logic          tx_wr,
  input  logic [DW-1:0] tx_wdata,
  input  logic          rx_rd,
  input  logic          load_take,
  input  logic          byte_rcvd,
  input  logic [DW-1:0] rx_byte,
  input  logic          xfer_busy,
  input  logic          ss_in,
  output logic [DW-1:0] tx_byte,
  output logic [DW-1:0] rx_rdata,
  output logic          tx_empty,
  output logic          rx_full,
  output logic          ovf,
  output logic          modf,
  output logic          tx_irq,
  output logic          ss_gpio,
  output logic [7:0]    clk_div
);
  localparam int CW = 6;

  logic [CW-1:0] ctrl;
  logic          ovf_arm, modf_arm;

  logic [1:0] rate;
  logic       fault_en, tx_ie, master, spi_en;
  assign rate     = ctrl[1:0];
  assign fault_en = ctrl[2];
  assign tx_ie    = ctrl[3];
  assign master   = ctrl[4];
  assign spi_en   = ctrl[5];

  logic ovf_set, rx_load, modf_set;
  assign ovf_set  = byte_rcvd & rx_full & ~rx_rd;
  assign rx_load  = byte_rcvd & ~ovf_set;
  assign modf_set = spi_en & fault_en & (master ? ~ss_in : (ss_in & xfer_busy));

  assign tx_irq  = tx_empty & tx_ie;
  assign ss_gpio = spi_en & master & ~fault_en;
  assign clk_div = master ? (8'd2 << (2 * rate)) : 8'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl     <= '0;
      tx_byte  <= '0;
      tx_empty <= 1'b1;
    end else begin
      if (ctrl_wr) ctrl <= ctrl_wdata[CW-1:0];
      if (tx_wr) begin
        tx_byte  <= tx_wdata;
        tx_empty <= 1'b0;
      end else if (load_take) begin
        tx_empty <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_rdata <= '0;
      rx_full  <= 1'b0;
    end else if (rx_load) begin
      rx_rdata <= rx_byte;
      rx_full  <= 1'b1;
    end else if (rx_rd) begin
      rx_full  <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf     <= 1'b0;
      ovf_arm <= 1'b0;
    end else if (ovf_set) begin
      ovf     <= 1'b1;
      ovf_arm <= 1'b0;
    end else if (rx_rd && ovf_arm) begin
      ovf     <= 1'b0;
      ovf_arm <= 1'b0;
    end else if (stat_rd && ovf) begin
      ovf_arm <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      modf     <= 1'b0;
      modf_arm <= 1'b0;
    end else if (modf_set) begin
      modf     <= 1'b1;
      modf_arm <= 1'b0;
    end else if (ctrl_wr && modf_arm) begin
      modf     <= 1'b0;
      modf_arm <= 1'b0;
    end else if (stat_rd && modf) begin
      modf_arm <= 1'b1;
    end
  end
endmodule

// File: rtl/spi_flag_ctl_chk.sv
module spi_flag_ctl_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ctrl_wr,
  input logic          tx_wr,
  input logic          rx_rd,
  input logic          byte_rcvd,
  input logic          ss_in,
  input logic          spi_en,
  input logic          master,
  input logic          fault_en,
  input logic [DW-1:0] rx_rdata,
  input logic          tx_empty,
  input logic          rx_full,
  input logic          ovf,
  input logic          modf,
  input logic          tx_irq
);
  p_txwr_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tx_wr |=> !tx_empty);

  p_irq_needs_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq |-> tx_empty);

  p_ovf_keeps_old_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_rcvd && rx_full && !rx_rd) |=> (ovf && $stable(rx_rdata)));

  p_ovf_clear_path_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ovf) |-> $past(rx_rd));

  p_master_fault_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_en && master && fault_en && !ss_in) |=> modf);

  p_modf_clear_path_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(modf) |-> $past(ctrl_wr));
endmodule

bind spi_flag_ctl spi_flag_ctl_chk #(.DW(DW)) u_chk (.*);

// File: tb/spi_flag_ctl_test.sv
module spi_flag_ctl_test;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctrl_wr = 0, stat_rd = 0, tx_wr = 0, rx_rd = 0;
  logic load_take = 0, byte_rcvd = 0, xfer_busy = 0, ss_in = 1;
  logic [7:0] ctrl_wdata = 0;
  logic [DW-1:0] tx_wdata = 0, rx_byte = 0;
  logic [DW-1:0] tx_byte, rx_rdata;
  logic tx_empty, rx_full, ovf, modf, tx_irq, ss_gpio;
  logic [7:0] clk_div;

  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  spi_flag_ctl #(.DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
    .stat_rd(stat_rd), .tx_wr(tx_wr), .tx_wdata(tx_wdata), .rx_rd(rx_rd),
    .load_take(load_take), .byte_rcvd(byte_rcvd), .rx_byte(rx_byte),
    .xfer_busy(xfer_busy), .ss_in(ss_in), .tx_byte(tx_byte), .rx_rdata(rx_rdata),
    .tx_empty(tx_empty), .rx_full(rx_full), .ovf(ovf), .modf(modf),
    .tx_irq(tx_irq), .ss_gpio(ss_gpio), .clk_div(clk_div)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_ctrl(input logic [7:0] d);
    @(negedge clk); ctrl_wr = 1; ctrl_wdata = d;
    @(negedge clk); ctrl_wr = 0;
  endtask
  task automatic rd_stat;
    @(negedge clk); stat_rd = 1;
    @(negedge clk); stat_rd = 0;
  endtask
  task automatic rd_rx;
    @(negedge clk); rx_rd = 1;
    @(negedge clk); rx_rd = 0;
  endtask
  task automatic wr_tx(input logic [DW-1:0] d);
    @(negedge clk); tx_wr = 1; tx_wdata = d;
    @(negedge clk); tx_wr = 0;
  endtask
  task automatic take;
    @(negedge clk); load_take = 1;
    @(negedge clk); load_take = 0;
  endtask
  task automatic rcv(input logic [DW-1:0] d);
    @(negedge clk); byte_rcvd = 1; rx_byte = d;
    @(negedge clk); byte_rcvd = 0;
  endtask

  task automatic t_reset;
    chk("R1 reset tx_empty", tx_empty, 1);
    chk("R3 reset rx_full", rx_full, 0);
    chk("R5 reset ovf", ovf, 0);
    chk("R8 reset modf", modf, 0);
    chk("R2 reset tx_irq", tx_irq, 0);
    chk("R11 reset ss_gpio", ss_gpio, 0);
    chk("R10 reset clk_div", clk_div, 0);
  endtask

  task automatic t_tx;
    wr_ctrl(8'h08);
    chk("R2 irq when empty", tx_irq, 1);
    wr_tx(8'hA5);
    chk("R1 write clears", tx_empty, 0);
    chk("R1 byte latched", tx_byte, 8'hA5);
    chk("R2 irq off when full", tx_irq, 0);
    take;
    chk("R1 take sets", tx_empty, 1);
    chk("R2 irq back", tx_irq, 1);
    @(negedge clk); tx_wr = 1; load_take = 1; tx_wdata = 8'h5A;
    @(negedge clk); tx_wr = 0; load_take = 0;
    chk("R1 write beats take", tx_empty, 0);
    wr_ctrl(8'h00);
    take;
    chk("R2 irq disabled", tx_irq, 0);
  endtask

  task automatic t_rx;
    rcv(8'h3C);
    chk("R3 full set", rx_full, 1);
    chk("R3 data loaded", rx_rdata, 8'h3C);
    rcv(8'h77);
    chk("R4 ovf set", ovf, 1);
    chk("R4 old byte kept", rx_rdata, 8'h3C);
    rd_rx;
    chk("R5 read alone keeps ovf", ovf, 1);
    chk("R3 read clears full", rx_full, 0);
    rcv(8'h11);
    chk("R3 reload", rx_rdata, 8'h11);
    rd_stat;
    chk("R5 step one no clear", ovf, 1);
    rd_rx;
    chk("R5 sequence clears", ovf, 0);
    rcv(8'h22);
    rcv(8'h33);
    rd_stat;
    rcv(8'h44);
    rd_rx;
    chk("R5 reset of arm", ovf, 1);
    chk("R4 data after ovf", rx_rdata, 8'h22);
    rd_stat;
    rd_rx;
    chk("R5 rearmed clear", ovf, 0);
  endtask

  task automatic t_modf;
    ss_in = 1;
    wr_ctrl(8'h34);
    chk("R6 ss high no fault", modf, 0);
    @(negedge clk); ss_in = 0;
    @(negedge clk); ss_in = 1;
    chk("R6 master ss low", modf, 1);
    wr_ctrl(8'h30);
    chk("R8 enable clear alone keeps", modf, 1);
    rd_stat;
    chk("R8 step one no clear", modf, 1);
    wr_ctrl(8'h30);
    chk("R8 sequence clears", modf, 0);
    @(negedge clk); ss_in = 0;
    @(negedge clk);
    chk("R9 master no enable", modf, 0);
    chk("R11 gpio free", ss_gpio, 1);
    ss_in = 1;
    wr_ctrl(8'h24);
    chk("R11 slave gpio", ss_gpio, 0);
    @(negedge clk);
    chk("R7 idle ss high", modf, 0);
    @(negedge clk); xfer_busy = 1;
    @(negedge clk); xfer_busy = 0;
    chk("R7 busy ss high", modf, 1);
    rd_stat;
    wr_ctrl(8'h20);
    chk("R8 slave clear", modf, 0);
    @(negedge clk); xfer_busy = 1;
    @(negedge clk); xfer_busy = 0;
    chk("R9 slave no enable", modf, 0);
    wr_ctrl(8'h34);
    chk("R11 enable blocks gpio", ss_gpio, 0);
  endtask

  task automatic t_div;
    for (int r = 0; r < 4; r++) begin
      wr_ctrl(8'h30 | 8'(r));
      chk("R10 master divisor", clk_div, 32'd2 << (2 * r));
    end
    wr_ctrl(8'h23);
    chk("R10 slave ignores rate", clk_div, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_tx;
    t_rx;
    t_modf;
    t_div;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule